// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page translations for a single address space. A 20-bit virtual byte address is split into a 10-bit virtual page number and a 10-bit offset within a 1 KB page. The page number is compared against the tag of every valid entry in the same cycle. On a match, the block returns an 18-bit physical address one cycle later. That address is the stored 8-bit frame number joined to the unchanged offset.

When no entry matches, the block holds the page number on a refill request port and waits for an external page-table walker to supply the frame through a valid/ready handshake. The new translation goes into a free slot if one exists. Otherwise it replaces a victim chosen with a reference-bit clock approximation of least-recently-used order. The victim's page number, frame, dirty bit and reference bit are presented for one cycle so the page table can be updated.

Dirty and reference information lives only in the cached entry until that entry is displaced. Four free-running counters report hits, misses, displacements of a valid entry and refills.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, all four counters read zero, `req_ready` is 1, and `resp_valid`, `refill_req_valid` and `evict_valid` are 0.
- R2: A lookup accepted with `req_valid` and `req_ready` that matches a valid entry gives, on the next cycle, `resp_valid`=1 and `resp_hit`=1. In the same cycle `resp_paddr` equals {stored frame, address bits 9:0}.
- R3: A lookup that matches no entry gives, on the next cycle, `refill_req_valid`=1 with `refill_req_vpn` equal to address bits 19:10. `req_ready` then stays 0 and no response is given until the refill handshake completes, however long `refill_valid` is withheld.
- R4: In a cycle where `refill_valid` and `refill_ready` are both 1, the refill is taken. One cycle later `resp_valid`=1, `resp_hit`=0 and `resp_paddr` equals {`refill_frame`, pending offset}. `req_ready` is 1 again in that cycle.
- R5: While any entry is invalid, a refill fills the lowest-indexed invalid entry and displaces nothing.
- R6: When all entries are valid, the victim is the lowest-indexed entry whose reference bit is 0. If every reference bit is 1, all reference bits are cleared and entry 0 is the victim.
- R7: A hit sets the entry's reference bit. A refilled entry starts with its reference bit set. This is observable because a referenced entry is skipped by the next victim choice.
- R8: A write access that hits sets the entry's dirty bit. A refilled entry's dirty bit equals the write flag of the access that missed. On displacement, `evict_vpn`, `evict_frame`, `evict_dirty` and `evict_ref` carry the victim's tag, frame, dirty bit and reference bit, read before any clearing.
- R9: Counters add one per hit (`hit_count`), per miss (`miss_count`), per displaced valid entry (`shootdown_count`) and per refill (`fill_count`).
- R10: `evict_valid` pulses for exactly one cycle, one cycle after a refill that displaces a valid entry, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | 20 | Virtual byte address |
| req_write | input | 1 | Access is a write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from a cached entry |
| resp_paddr | output | 18 | Translated physical byte address |
| refill_req_valid | output | 1 | Waiting for a translation from the page table |
| refill_req_vpn | output | 10 | Page number to be walked |
| refill_valid | input | 1 | Page table offers a translation |
| refill_ready | output | 1 | Block accepts the offered translation |
| refill_frame | input | 8 | Frame number of the offered translation |
| evict_valid | output | 1 | One-cycle strobe: a valid entry was displaced |
| evict_vpn | output | 10 | Tag of the displaced entry |
| evict_frame | output | 8 | Frame of the displaced entry |
| evict_dirty | output | 1 | Dirty bit of the displaced entry |
| evict_ref | output | 1 | Reference bit of the displaced entry |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |
| shootdown_count | output | 16 | Number of valid entries displaced |
| fill_count | output | 16 | Number of refills written |

## Verification
The hardest state to reach from the ports is a full buffer in which the reference bits are mixed. This only arises after one sweep has cleared every bit and later hits have set some of them again. The stimulus first fills all slots so every reference bit is set, then forces a miss to trigger the sweep. Next it hits one low-indexed entry and sends two more misses, so the victim choice must skip that entry. A long pseudo-random run over a page range slightly larger than the buffer, with random write flags and random refill delays, then drives both eviction paths repeatedly. A bench-side model, derived from the placement and victim rules, predicts every displaced tag, frame, dirty bit and reference bit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic {
      ST_LOOKUP = 1'b0,
      ST_REFILL = 1'b1
   } xlat_state_e;

   // one-cycle events feeding the statistics counters
   typedef struct packed {
      logic fill;
      logic shoot;
      logic miss;
      logic hit;
   } xlat_evt_t;

   localparam int XLAT_NUM_EVT = 4;

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter  int ENTRIES = 8,
   parameter  int VPN_W   = 10,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [VPN_W-1:0]   vpn_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [VPN_W-1:0]   tag_i [ENTRIES],
   output logic               hit_o,
   output logic [IDX_W-1:0]   idx_o
);

   logic [ENTRIES-1:0] eq;

   // one comparator per slot, all in parallel
   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         assign eq[g] = valid_i[g] && (tag_i[g] == vpn_i);
      end
   endgenerate

   always_comb begin
      hit_o = |eq;
      idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter  int ENTRIES = 8,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] ref_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic               occupied_o,
   output logic               sweep_o
);

   always_comb begin
      idx_o      = '0;
      occupied_o = &valid_i;
      sweep_o    = 1'b0;
      if (!occupied_o) begin
         // free slot available: lowest invalid index
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) idx_o = IDX_W'(i);
         end
      end else if (&ref_i) begin
         // every slot recently used: clear all, restart at slot 0
         sweep_o = 1'b1;
         idx_o   = '0;
      end else begin
         for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ref_i[i]) idx_o = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/xlat_stats.sv
module xlat_stats
   import xlat_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xlat_evt_t        evt_i,
   output logic [CNT_W-1:0] hit_o,
   output logic [CNT_W-1:0] miss_o,
   output logic [CNT_W-1:0] shoot_o,
   output logic [CNT_W-1:0] fill_o
);

   logic [XLAT_NUM_EVT-1:0] ev_bits;
   logic [CNT_W-1:0]        cnt_q [XLAT_NUM_EVT];

   assign ev_bits = {evt_i.fill, evt_i.shoot, evt_i.miss, evt_i.hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < XLAT_NUM_EVT; k++) cnt_q[k] <= '0;
      end else begin
         for (int k = 0; k < XLAT_NUM_EVT; k++) begin
            if (ev_bits[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
         end
      end
   end

   assign hit_o   = cnt_q[0];
   assign miss_o  = cnt_q[1];
   assign shoot_o = cnt_q[2];
   assign fill_o  = cnt_q[3];

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter  int VA_W    = 20,
   parameter  int PA_W    = 18,
   parameter  int OFF_W   = 10,
   parameter  int ENTRIES = 8,
   parameter  int CNT_W   = 16,
   localparam int VPN_W   = VA_W - OFF_W,
   localparam int PFN_W   = PA_W - OFF_W,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             resp_valid,
   output logic             resp_hit,
   output logic [PA_W-1:0]  resp_paddr,
   output logic             refill_req_valid,
   output logic [VPN_W-1:0] refill_req_vpn,
   input  logic             refill_valid,
   output logic             refill_ready,
   input  logic [PFN_W-1:0] refill_frame,
   output logic             evict_valid,
   output logic [VPN_W-1:0] evict_vpn,
   output logic [PFN_W-1:0] evict_frame,
   output logic             evict_dirty,
   output logic             evict_ref,
   output logic [CNT_W-1:0] hit_count,
   output logic [CNT_W-1:0] miss_count,
   output logic [CNT_W-1:0] shootdown_count,
   output logic [CNT_W-1:0] fill_count
);

   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("xlat_cache: ENTRIES must be at least 2");
      end
      if (OFF_W < 1 || VA_W <= OFF_W || PA_W <= OFF_W) begin : g_bad_widths
         $error("xlat_cache: address widths must exceed the offset width");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("xlat_cache: CNT_W must be positive");
      end
   endgenerate

   xlat_state_e      st_q;
   logic [VPN_W-1:0] pend_vpn_q;
   logic [OFF_W-1:0] pend_off_q;
   logic             pend_wr_q;

   logic [ENTRIES-1:0] v_q, d_q, r_q;
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [PFN_W-1:0]   frm_q [ENTRIES];

   logic             resp_valid_q, resp_hit_q;
   logic [PA_W-1:0]  resp_paddr_q;
   logic             evict_valid_q, evict_dirty_q, evict_ref_q;
   logic [VPN_W-1:0] evict_vpn_q;
   logic [PFN_W-1:0] evict_frame_q;

   logic [VPN_W-1:0] look_vpn;
   logic [OFF_W-1:0] look_off;
   logic             m_hit;
   logic [IDX_W-1:0] m_idx;
   logic [IDX_W-1:0] vic_idx;
   logic             vic_occ, vic_sweep;
   logic             accept, fill;
   xlat_evt_t        evt;

   assign look_vpn = req_vaddr[VA_W-1:OFF_W];
   assign look_off = req_vaddr[OFF_W-1:0];

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
      .vpn_i   (look_vpn),
      .valid_i (v_q),
      .tag_i   (tag_q),
      .hit_o   (m_hit),
      .idx_o   (m_idx)
   );

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .valid_i    (v_q),
      .ref_i      (r_q),
      .idx_o      (vic_idx),
      .occupied_o (vic_occ),
      .sweep_o    (vic_sweep)
   );

   assign req_ready        = (st_q == ST_LOOKUP);
   assign refill_ready     = (st_q == ST_REFILL);
   assign refill_req_valid = (st_q == ST_REFILL);
   assign refill_req_vpn   = pend_vpn_q;

   assign accept = req_valid && (st_q == ST_LOOKUP);
   assign fill   = refill_valid && (st_q == ST_REFILL);

   assign evt.hit   = accept && m_hit;
   assign evt.miss  = accept && !m_hit;
   assign evt.fill  = fill;
   assign evt.shoot = fill && vic_occ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q          <= ST_LOOKUP;
         pend_vpn_q    <= '0;
         pend_off_q    <= '0;
         pend_wr_q     <= 1'b0;
         v_q           <= '0;
         d_q           <= '0;
         r_q           <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i] <= '0;
            frm_q[i] <= '0;
         end
         resp_valid_q  <= 1'b0;
         resp_hit_q    <= 1'b0;
         resp_paddr_q  <= '0;
         evict_valid_q <= 1'b0;
         evict_vpn_q   <= '0;
         evict_frame_q <= '0;
         evict_dirty_q <= 1'b0;
         evict_ref_q   <= 1'b0;
      end else begin
         resp_valid_q  <= 1'b0;
         evict_valid_q <= 1'b0;

         if (accept) begin
            if (m_hit) begin
               r_q[m_idx]   <= 1'b1;
               if (req_write) d_q[m_idx] <= 1'b1;
               resp_valid_q <= 1'b1;
               resp_hit_q   <= 1'b1;
               resp_paddr_q <= {frm_q[m_idx], look_off};
            end else begin
               st_q       <= ST_REFILL;
               pend_vpn_q <= look_vpn;
               pend_off_q <= look_off;
               pend_wr_q  <= req_write;
            end
         end

         if (fill) begin
            if (vic_sweep) r_q <= '0;
            // victim state leaves through the write-back strobe
            evict_valid_q    <= vic_occ;
            evict_vpn_q      <= tag_q[vic_idx];
            evict_frame_q    <= frm_q[vic_idx];
            evict_dirty_q    <= d_q[vic_idx];
            evict_ref_q      <= r_q[vic_idx];
            v_q[vic_idx]     <= 1'b1;
            d_q[vic_idx]     <= pend_wr_q;
            r_q[vic_idx]     <= 1'b1;
            tag_q[vic_idx]   <= pend_vpn_q;
            frm_q[vic_idx]   <= refill_frame;
            resp_valid_q     <= 1'b1;
            resp_hit_q       <= 1'b0;
            resp_paddr_q     <= {refill_frame, pend_off_q};
            st_q             <= ST_LOOKUP;
         end
      end
   end

   assign resp_valid  = resp_valid_q;
   assign resp_hit    = resp_hit_q;
   assign resp_paddr  = resp_paddr_q;
   assign evict_valid = evict_valid_q;
   assign evict_vpn   = evict_vpn_q;
   assign evict_frame = evict_frame_q;
   assign evict_dirty = evict_dirty_q;
   assign evict_ref   = evict_ref_q;

   xlat_stats #(.CNT_W(CNT_W)) u_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt),
      .hit_o   (hit_count),
      .miss_o  (miss_count),
      .shoot_o (shootdown_count),
      .fill_o  (fill_count)
   );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             resp_valid,
   input logic             resp_hit,
   input logic             refill_req_valid,
   input logic             refill_valid,
   input logic             refill_ready,
   input logic             evict_valid,
   input logic [CNT_W-1:0] hit_count,
   input logic [CNT_W-1:0] miss_count,
   input logic [CNT_W-1:0] shootdown_count,
   input logic [CNT_W-1:0] fill_count
);

   a_r3_wait_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      refill_req_valid |-> !req_ready);

   a_r2_accept_has_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (resp_valid != refill_req_valid));

   a_r4_fill_gives_miss_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (refill_valid && refill_ready) |=> (resp_valid && !resp_hit && req_ready));

   a_r10_evict_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> $past(refill_valid && refill_ready));

   a_r10_evict_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |=> !evict_valid);

   a_r9_hit_counter: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> hit_count == CNT_W'($past(hit_count) + 1'b1));

   a_r9_fill_counter: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> fill_count == CNT_W'($past(fill_count) + 1'b1));

   a_r9_shoot_counter: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> shootdown_count == CNT_W'($past(shootdown_count) + 1'b1));

   a_r9_miss_counter: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refill_req_valid) |-> miss_count == CNT_W'($past(miss_count) + 1'b1));

endmodule

bind xlat_cache xlat_cache_chk #(.CNT_W(CNT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_ready        (req_ready),
   .resp_valid       (resp_valid),
   .resp_hit         (resp_hit),
   .refill_req_valid (refill_req_valid),
   .refill_valid     (refill_valid),
   .refill_ready     (refill_ready),
   .evict_valid      (evict_valid),
   .hit_count        (hit_count),
   .miss_count       (miss_count),
   .shootdown_count  (shootdown_count),
   .fill_count       (fill_count)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

   localparam int VA_W = 20, PA_W = 18, OFF_W = 10, ENTRIES = 8, CNT_W = 16;
   localparam int VPN_W = VA_W - OFF_W, PFN_W = PA_W - OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, refill_valid = 1'b0;
   logic [VA_W-1:0]  req_vaddr = '0;
   logic [PFN_W-1:0] refill_frame = '0;
   logic req_ready, resp_valid, resp_hit, refill_req_valid, refill_ready;
   logic evict_valid, evict_dirty, evict_ref;
   logic [PA_W-1:0]  resp_paddr;
   logic [VPN_W-1:0] refill_req_vpn, evict_vpn;
   logic [PFN_W-1:0] evict_frame;
   logic [CNT_W-1:0] hit_count, miss_count, shootdown_count, fill_count;

   always #2 clk = ~clk;

   xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_write(req_write), .resp_valid(resp_valid),
      .resp_hit(resp_hit), .resp_paddr(resp_paddr), .refill_req_valid(refill_req_valid),
      .refill_req_vpn(refill_req_vpn), .refill_valid(refill_valid), .refill_ready(refill_ready),
      .refill_frame(refill_frame), .evict_valid(evict_valid), .evict_vpn(evict_vpn),
      .evict_frame(evict_frame), .evict_dirty(evict_dirty), .evict_ref(evict_ref),
      .hit_count(hit_count), .miss_count(miss_count), .shootdown_count(shootdown_count),
      .fill_count(fill_count)
   );

   // bench model of the entries
   logic [ENTRIES-1:0] mv = '0, md = '0, mr = '0;
   logic [VPN_W-1:0]   mt [ENTRIES];
   logic [PFN_W-1:0]   mf [ENTRIES];
   int e_hit = 0, e_miss = 0, e_shoot = 0, e_fill = 0;
   int n_chk = 0, n_err = 0;
   logic [31:0] seed = 32'h1234_5678;
   logic done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [PFN_W-1:0] frame_of(input logic [VPN_W-1:0] v);
      return PFN_W'(32'(v) * 7 + 3);
   endfunction

   task automatic chk_counts();
      chk("R9 hit_count",        32'(hit_count),       32'(e_hit));
      chk("R9 miss_count",       32'(miss_count),      32'(e_miss));
      chk("R9 shootdown_count",  32'(shootdown_count), 32'(e_shoot));
      chk("R9 fill_count",       32'(fill_count),      32'(e_fill));
   endtask

   task automatic access(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                         input logic wr, input int stall);
      logic hit;
      int hi, vi;
      logic vocc, vsweep;
      logic [PFN_W-1:0] fr;
      hit = 1'b0; hi = 0;
      for (int i = 0; i < ENTRIES; i++) if (mv[i] && mt[i] == vpn) begin hit = 1'b1; hi = i; end
      @(negedge clk);
      chk("R3 ready before lookup", 32'(req_ready), 32'd1);
      req_valid = 1'b1; req_vaddr = {vpn, off}; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      if (hit) begin
         chk("R2 resp_valid", 32'(resp_valid), 32'd1);
         chk("R2 resp_hit", 32'(resp_hit), 32'd1);
         chk("R2 paddr", 32'(resp_paddr), 32'({mf[hi], off}));
         chk("R10 no evict on hit", 32'(evict_valid), 32'd0);
         mr[hi] = 1'b1;
         if (wr) md[hi] = 1'b1;
         e_hit++;
      end else begin
         e_miss++;
         chk("R3 no resp on miss", 32'(resp_valid), 32'd0);
         chk("R3 refill request", 32'(refill_req_valid), 32'd1);
         chk("R3 refill vpn", 32'(refill_req_vpn), 32'(vpn));
         chk("R3 not ready", 32'(req_ready), 32'd0);
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R3 request held", 32'(refill_req_valid), 32'd1);
            chk("R3 resp withheld", 32'(resp_valid), 32'd0);
         end
         vocc = &mv; vsweep = 1'b0; vi = 0;
         if (!vocc) begin
            for (int i = ENTRIES - 1; i >= 0; i--) if (!mv[i]) vi = i;
         end else if (&mr) begin
            vsweep = 1'b1; vi = 0;
         end else begin
            for (int i = ENTRIES - 1; i >= 0; i--) if (!mr[i]) vi = i;
         end
         fr = frame_of(vpn);
         refill_valid = 1'b1; refill_frame = fr;
         chk("R4 refill_ready", 32'(refill_ready), 32'd1);
         @(negedge clk);
         refill_valid = 1'b0;
         chk("R4 resp_valid", 32'(resp_valid), 32'd1);
         chk("R4 resp_hit low", 32'(resp_hit), 32'd0);
         chk("R4 paddr", 32'(resp_paddr), 32'({fr, off}));
         chk("R4 ready again", 32'(req_ready), 32'd1);
         chk("R5/R10 evict_valid", 32'(evict_valid), 32'(vocc));
         if (vocc) begin
            chk("R6 evict_vpn", 32'(evict_vpn), 32'(mt[vi]));
            chk("R8 evict_frame", 32'(evict_frame), 32'(mf[vi]));
            chk("R8 evict_dirty", 32'(evict_dirty), 32'(md[vi]));
            chk("R8 evict_ref", 32'(evict_ref), 32'(mr[vi]));
            e_shoot++;
         end
         e_fill++;
         if (vsweep) mr = '0;
         mv[vi] = 1'b1; md[vi] = wr; mr[vi] = 1'b1; mt[vi] = vpn; mf[vi] = fr;
      end
      chk_counts();
   endtask

   initial begin
      for (int i = 0; i < ENTRIES; i++) begin mt[i] = '0; mf[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 req_ready", 32'(req_ready), 32'd1);
      chk("R1 resp_valid", 32'(resp_valid), 32'd0);
      chk("R1 refill_req_valid", 32'(refill_req_valid), 32'd0);
      chk("R1 evict_valid", 32'(evict_valid), 32'd0);
      chk_counts();
      rst_n = 1'b1;

      // R5: fill every slot, odd pages written
      for (int p = 0; p < ENTRIES; p++) access(VPN_W'(p), OFF_W'(p * 131), p[0], p % 3);
      chk("R5 no shootdown while filling", 32'(shootdown_count), 32'd0);
      // first lookup after fill: all entries hit (R1 invalid start proven by misses above)
      access(10'd0, 10'd1023, 1'b1, 0);   // R8 write hit sets dirty
      access(10'd2, 10'd0, 1'b0, 0);
      // R6: all references set -> sweep, slot 0 leaves
      access(10'd100, 10'd5, 1'b0, 1);
      chk("R6 sweep victim is slot 0", 32'(evict_vpn), 32'd0);
      chk("R6 victim ref read before clear", 32'(evict_ref), 32'd1);
      chk("R8 dirty from write hit", 32'(evict_dirty), 32'd1);
      // R7: hit page 2 so it is skipped
      access(10'd2, 10'd77, 1'b0, 0);
      access(10'd101, 10'd9, 1'b1, 0);
      chk("R6 lowest unreferenced slot", 32'(evict_vpn), 32'd1);
      chk("R8 dirty from install write", 32'(evict_dirty), 32'd1);
      access(10'd102, 10'd512, 1'b0, 2);
      chk("R7 referenced slot skipped", 32'(evict_vpn), 32'd3);
      access(10'd1023, 10'd1023, 1'b1, 0);
      access(10'd1023, 10'd0, 1'b0, 0);

      // near-exhaustive mix over twelve pages plus the top page
      for (int n = 0; n < 600; n++) begin
         logic [VPN_W-1:0] vp;
         seed = seed * 32'd1664525 + 32'd1013904223;
         vp = ((seed >> 28) == 0) ? 10'd1023 : VPN_W'((seed >> 20) % 12);
         access(vp, OFF_W'(seed >> 4), seed[14], int'((seed >> 8) % 3));
      end
      chk_counts();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule